// File: doc/BRIEF.md
# Four-Channel Ping-Pong Scan-Line Buffer

This block stores scan-line video for four display channels in two alternating buffers. While the display side streams one buffer out, the host fills the other buffer with the next line. A one-cycle swap strobe from the timing generator exchanges the two roles at the end of every line. The host sends whole 16-bit words: first a complete line for channel 0, then one for channel 1, and so on through channel 3. The display side reads one location per clock, and each location gives one 4-bit nibble for each of the four channels at once.

Each buffer is split into four nibble-wide banks, and every bank has its own address. A host word is spread diagonally over the banks, one nibble per bank, so that the four nibbles land at four consecutive locations. The display side then reads one location across all four banks and rotates the result back, so each channel gets its own nibble. A 6-bit write pointer supplies the upper address bits. It wraps back to a programmed start value, which means a line of fixed length leaves the pointer where it started. A control-insert input replaces the video on all channels with control nibbles, for example during sync.

Top module: `quad_pingpong_linebuf`

## Requirements
- R1: While reset is asserted, every channel output is 0, the read side uses buffer A and host writes go to buffer B.
- R2: A host word for channel t written at pointer p places its nibble k at location 4p+k in bank (t+k) mod 4 of the write buffer. Nibble k=0 is bits 15:12 and nibble k=3 is bits 3:0.
- R3: Reading location a gives channel t the nibble a mod 4 of the word that channel t wrote at pointer a/4. Channel t appears on ch_out bits 4t+3:4t.
- R4: Each host write without force-load advances the pointer by one. A write made with the pointer at 63 reloads it from start_val. With no write, the pointer holds its value.
- R5: With force_load high, each host write goes to the current pointer and then reloads the pointer from start_val.
- R6: Host writes never change what the read side returns. Each swap strobe exchanges the read buffer and the write buffer.
- R7: When send_ctrl is high at a clock edge, ch_out takes ctrl_in (same channel layout as R3) at that edge in place of video.
- R8: Video for a read address presented at edge n appears on ch_out after edge n+1. The output still shows the previous location's video after edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_chan | input | 2 | Channel that owns the written word |
| wr_data | input | 16 | Host word, most significant nibble first on screen |
| force_load | input | 1 | Reload the pointer from start_val on every write |
| start_val | input | 6 | Pointer start value (64 minus words per line) |
| switch_pulse | input | 1 | End-of-line swap strobe |
| rd_addr | input | 8 | Display-side read location |
| send_ctrl | input | 1 | Replace video with control nibbles |
| ctrl_in | input | 16 | Control nibbles, one per channel |
| ch_out | output | 16 | Per-channel output nibbles |

## Verification
The bench fills lines that wrap the pointer from a nonzero start. If the wrap went to zero, or the increment were off by one, a channel's data would turn up at the wrong locations. It reads back every location of a line, so a missing rotation on either the write side or the read side shows up as channels swapped with each other. It writes the inactive buffer in the middle of a line to catch writes that reach the buffer being displayed, and it swaps twice to confirm that the old line is still there. It also checks the force-load overwrite pattern, the one-cycle control insertion, and the exact two-edge read latency.

// File: rtl/qlb_pkg.sv
package qlb_pkg;
   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } buf_id_e;

   function automatic buf_id_e other_buf(buf_id_e b);
      return (b == BUF_A) ? BUF_B : BUF_A;
   endfunction
endpackage

// File: rtl/qlb_wr_ptr.sv
module qlb_wr_ptr #(
   parameter int PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             force_load,
   input  logic [PTR_W-1:0] start_val,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] PTR_LAST = '1;

   logic reload;
   assign reload = force_load || (ptr == PTR_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (wr_en) begin
         if (reload) ptr <= start_val;
         else        ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/qlb_bank.sv
module qlb_bank #(
   parameter int NIB_W  = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [NIB_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [NIB_W-1:0]  rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [NIB_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/qlb_rd_rot.sv
module qlb_rd_rot #(
   parameter int NCH   = 4,
   parameter int NIB_W = 4,
   localparam int CH_W   = $clog2(NCH),
   localparam int WORD_W = NCH * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] bank_q,
   input  logic [CH_W-1:0]   rot_k,
   input  logic              send_ctrl,
   input  logic [WORD_W-1:0] ctrl_in,
   output logic [WORD_W-1:0] ch_out
);
   logic [NIB_W-1:0]  bank_arr [NCH];
   logic [WORD_W-1:0] video;

   for (genvar b = 0; b < NCH; b++) begin : g_unpack
      assign bank_arr[b] = bank_q[b*NIB_W +: NIB_W];
   end

   for (genvar t = 0; t < NCH; t++) begin : g_chan
      localparam logic [CH_W-1:0] T_IDX = CH_W'(t);
      logic [CH_W-1:0] src;
      assign src = T_IDX + rot_k;
      assign video[t*NIB_W +: NIB_W] = bank_arr[src];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ch_out <= '0;
      else if (send_ctrl) ch_out <= ctrl_in;
      else                ch_out <= video;
   end
endmodule

// File: rtl/quad_pingpong_linebuf.sv
module quad_pingpong_linebuf
   import qlb_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int NIB_W = 4,
   parameter int PTR_W = 6,
   localparam int CH_W   = $clog2(NCH),
   localparam int WORD_W = NCH * NIB_W,
   localparam int ADDR_W = PTR_W + CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_chan,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              force_load,
   input  logic [PTR_W-1:0]  start_val,
   input  logic              switch_pulse,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              send_ctrl,
   input  logic [WORD_W-1:0] ctrl_in,
   output logic [WORD_W-1:0] ch_out
);
   if (NCH < 2 || (1 << CH_W) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (NIB_W < 1) begin : g_bad_nib
      $error("NIB_W must be at least 1");
   end
   if (PTR_W < 1) begin : g_bad_ptr
      $error("PTR_W must be at least 1");
   end

   localparam int NBUF = 2;

   buf_id_e           rd_sel;
   buf_id_e           wr_buf;
   buf_id_e           sel_q;
   logic [CH_W-1:0]   rot_q;
   logic [PTR_W-1:0]  wr_ptr;
   logic [NIB_W-1:0]  wnib [NCH];
   logic [CH_W-1:0]   wk   [NCH];
   logic [NBUF*WORD_W-1:0] bank_all;
   logic [WORD_W-1:0] rd_word;

   assign wr_buf = other_buf(rd_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rd_sel <= BUF_A;
      else if (switch_pulse) rd_sel <= other_buf(rd_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= BUF_A;
         rot_q <= '0;
      end else begin
         sel_q <= rd_sel;
         rot_q <= rd_addr[CH_W-1:0];
      end
   end

   qlb_wr_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .force_load (force_load),
      .start_val  (start_val),
      .ptr        (wr_ptr)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_wnib
      assign wnib[k] = wr_data[WORD_W-1-k*NIB_W -: NIB_W];
   end

   for (genvar b = 0; b < NCH; b++) begin : g_wk
      assign wk[b] = CH_W'(b) - wr_chan;
   end

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      localparam buf_id_e G_ID = buf_id_e'(g);
      logic buf_we;
      assign buf_we = wr_en && (wr_buf == G_ID);
      for (genvar b = 0; b < NCH; b++) begin : g_bank
         qlb_bank #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_bank (
            .clk   (clk),
            .we    (buf_we),
            .waddr ({wr_ptr, wk[b]}),
            .wdata (wnib[wk[b]]),
            .raddr (rd_addr),
            .rdata (bank_all[g*WORD_W + b*NIB_W +: NIB_W])
         );
      end
   end

   assign rd_word = (sel_q == BUF_A) ? bank_all[0 +: WORD_W]
                                     : bank_all[WORD_W +: WORD_W];

   qlb_rd_rot #(.NCH(NCH), .NIB_W(NIB_W)) u_rot (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_q    (rd_word),
      .rot_k     (rot_q),
      .send_ctrl (send_ctrl),
      .ctrl_in   (ctrl_in),
      .ch_out    (ch_out)
   );
endmodule

// File: rtl/qlb_chk.sv
module qlb_chk
   import qlb_pkg::*;
#(
   parameter int PTR_W  = 6,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              force_load,
   input logic [PTR_W-1:0]  start_val,
   input logic              switch_pulse,
   input logic              send_ctrl,
   input logic [WORD_W-1:0] ctrl_in,
   input logic [WORD_W-1:0] ch_out,
   input logic [PTR_W-1:0]  wr_ptr,
   input buf_id_e           rd_sel
);
   localparam logic [PTR_W-1:0] LAST = '1;

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !force_load && wr_ptr != LAST) |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));

   // R4
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !force_load && wr_ptr == LAST) |=> wr_ptr == $past(start_val));

   // R4
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_ptr));

   // R5
   force_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && force_load) |=> wr_ptr == $past(start_val));

   // R6
   buf_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      switch_pulse |=> rd_sel != $past(rd_sel));

   // R6
   buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !switch_pulse |=> $stable(rd_sel));

   // R7
   ctrl_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      send_ctrl |=> ch_out == $past(ctrl_in));
endmodule

bind quad_pingpong_linebuf qlb_chk #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .force_load   (force_load),
   .start_val    (start_val),
   .switch_pulse (switch_pulse),
   .send_ctrl    (send_ctrl),
   .ctrl_in      (ctrl_in),
   .ch_out       (ch_out),
   .wr_ptr       (wr_ptr),
   .rd_sel       (rd_sel)
);

// File: tb/quad_pingpong_linebuf_tb.sv
module quad_pingpong_linebuf_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_chan = '0;
   logic [15:0] wr_data = '0;
   logic        force_load = 1'b0;
   logic [5:0]  start_val = '0;
   logic        switch_pulse = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic        send_ctrl = 1'b0;
   logic [15:0] ctrl_in = '0;
   logic [15:0] ch_out;

   always #5 clk = ~clk;

   quad_pingpong_linebuf u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
      .wr_data(wr_data), .force_load(force_load), .start_val(start_val),
      .switch_pulse(switch_pulse), .rd_addr(rd_addr), .send_ctrl(send_ctrl),
      .ctrl_in(ctrl_in), .ch_out(ch_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference store: [buffer][channel][pointer]
   logic [15:0] refw [2][4][64];
   int rp = 0;     // expected pointer
   int rsel = 0;   // expected read buffer

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_loc(int a);
      logic [15:0] r;
      int k;
      k = a % 4;
      for (int t = 0; t < 4; t++) begin
         logic [15:0] w;
         w = refw[rsel][t][a/4];
         r[t*4 +: 4] = w[15-4*k -: 4];
      end
      return r;
   endfunction

   task automatic put(int ch, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_chan = 2'(ch); wr_data = d;
      refw[1-rsel][ch][rp] = d;
      if (force_load || rp == 63) rp = int'(start_val);
      else rp++;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic swap();
      @(negedge clk); switch_pulse = 1'b1;
      @(negedge clk); switch_pulse = 1'b0;
      rsel = 1 - rsel;
   endtask

   task automatic rd(int a, output logic [15:0] v);
      @(negedge clk); rd_addr = 8'(a);
      @(negedge clk);
      @(negedge clk);
      v = ch_out;
   endtask

   task automatic init_ptr(int sv);
      start_val = 6'(sv);
      force_load = 1'b1;
      put(0, 16'h0000);
      force_load = 1'b0;
   endtask

   task automatic fill_line();
      for (int ch = 0; ch < 4; ch++)
         for (int i = 0; i < 16; i++) put(ch, 16'($urandom));
   endtask

   task automatic t_reset();
      check("R1", "outputs in reset", ch_out, 16'h0000);
   endtask

   task automatic t_line();
      logic [15:0] v;
      init_ptr(48);
      fill_line();
      swap();
      for (int a = 192; a < 256; a++) begin
         rd(a, v);
         check("R2 R3", $sformatf("loc %0d", a), v, exp_loc(a));
      end
   endtask

   task automatic t_pingpong();
      logic [15:0] v;
      for (int ch = 0; ch < 4; ch++) begin
         for (int i = 0; i < 16; i++) put(ch, 16'($urandom));
         if (ch == 1) begin
            rd(201, v);
            check("R6", "displayed line during writes", v, exp_loc(201));
         end
      end
      swap();
      for (int a = 192; a < 256; a++) begin
         rd(a, v);
         check("R6", $sformatf("new line loc %0d", a), v, exp_loc(a));
      end
      swap();
      for (int a = 220; a < 228; a++) begin
         rd(a, v);
         check("R6", $sformatf("old line kept loc %0d", a), v, exp_loc(a));
      end
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      init_ptr(60);
      for (int i = 0; i < 5; i++) put(0, 16'($urandom));
      swap();
      for (int a = 240; a < 256; a++) begin
         rd(a, v);
         check("R4", $sformatf("wrap loc %0d", a), v, exp_loc(a));
      end
   endtask

   task automatic t_force();
      logic [15:0] v;
      start_val = 6'd52;
      force_load = 1'b1;
      put(2, 16'h1234);
      put(2, 16'h5678);
      put(2, 16'h9ABC);
      force_load = 1'b0;
      swap();
      for (int a = 208; a < 212; a++) begin
         rd(a, v);
         check("R5", $sformatf("force loc %0d", a), v, exp_loc(a));
      end
      for (int a = 244; a < 248; a++) begin
         rd(a, v);
         check("R5", $sformatf("force loc %0d", a), v, exp_loc(a));
      end
   endtask

   task automatic t_ctrl();
      logic [15:0] v;
      @(negedge clk); send_ctrl = 1'b1; ctrl_in = 16'hA5C3;
      @(negedge clk);
      check("R7", "control nibbles", ch_out, 16'hA5C3);
      ctrl_in = 16'h0F1E;
      @(negedge clk);
      check("R7", "control nibbles update", ch_out, 16'h0F1E);
      send_ctrl = 1'b0;
      rd(210, v);
      check("R7", "video after control", v, exp_loc(210));
   endtask

   task automatic t_latency();
      logic [15:0] v1;
      rd(208, v1);
      check("R8", "first location", v1, exp_loc(208));
      @(negedge clk); rd_addr = 8'd245;
      @(negedge clk);
      check("R8", "one edge later still old", ch_out, exp_loc(208));
      @(negedge clk);
      check("R8", "two edges later new", ch_out, exp_loc(245));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_line();
      t_pingpong();
      t_wrap();
      t_force();
      t_ctrl();
      t_latency();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule